// File: doc/BRIEF.md
# Multiplexed Host Memory Port

This block lets an external host reach a target's on-chip program and data memories through one 16-bit bus that carries both addresses and data. The host first runs an address-latch access that loads a 14-bit word address together with a memory-type bit. After that it streams words with plain read or write accesses. The internal address advances by itself after each complete word, so a long block needs only one latch access.

Data-memory words are 16 bits wide and take one bus access each. Program-memory words are 24 bits wide and take two accesses. The upper 16 bits travel first. The lower 8 bits travel second in bus bits 7:0. The port writes the internal arrays directly and returns read data on a registered output. While the boot input is high, completing a program word at address zero raises a sticky start flag. A boot loader therefore fills the rest of memory first and writes the restart vector last.

All strobes are sampled on the rising clock edge. After each accepted access the port is busy for one cycle, and the acknowledge output shows this.

Top module: `mdsp_host_port`

## Requirements
- R1: While reset is held, and right after it is released, ack_n is 0, boot_done is 0 and bus_out is 0.
- R2: An access is accepted on a rising edge where sel_n is 0, ack_n is 0, and at least one of latch, rd_n=0 or wr_n=0 holds. An accepted access with latch=1 loads the address register from bus_in[13:0] and the memory type from bus_in[14], where 1 means data memory and 0 means program memory. bus_in[15] is ignored.
- R3: In data memory, every accepted write stores bus_in at the current address, and every accepted read returns the word at that address. The address then advances by one.
- R4: In program memory, a write takes two accesses. The first supplies bits 23:8 of the word. The second supplies bits 7:0 in bus_in[7:0], and its bus_in[15:8] is ignored. The word is stored, and the address advances, only after the second access.
- R5: In program memory, the first read access returns bits 23:8 of the word. The second returns bits 7:0 in bus_out[7:0] with bus_out[15:8]=0. The address advances after the second access.
- R6: After every accepted access ack_n is 1 for exactly one cycle and then returns to 0. A strobe still active during that busy cycle is ignored.
- R7: An access that asserts latch and wr_n=0 together acts only as an address-latch access. No memory location changes.
- R8: An address-latch access discards a half-finished program word. The next access counts as the first half of a new word.
- R9: When boot_en is 1 and the second half of a program write completes at address 0, boot_done goes to 1 from the next cycle on and stays 1 until reset. A first half alone, or the same write with boot_en at 0, leaves it at 0.
- R10: The address register is 14 bits and wraps from 0x3FFF to 0x0000. A memory with a depth below 2^14 uses the address modulo its depth.
- R11: bus_out changes only after an accepted read. When rd_n and wr_n are both 0 without latch, the access is a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all strobes sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_en | input | 1 | Boot mode; enables the start flag |
| sel_n | input | 1 | Port select, active low |
| latch | input | 1 | Address-latch strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 16 | Address or data from the host |
| bus_out | output | 16 | Registered read data to the host |
| ack_n | output | 1 | Ready acknowledge, active low; high while busy |
| boot_done | output | 1 | Sticky start flag set by the restart-vector write |

## Verification
The hardest state to reach from the ports is a program-word write that finishes at address 0 only because the address wrapped from 0x3FFF, while boot mode is on. That is the same step that raises the start flag. The stimulus latches 0x3FFF with boot_en high and writes two whole words. It checks the flag after the first word, after the lone first half of the second word, and after that word completes. It then reads location 0 back through both 0x0000 and the aliased address 0x0400. Random latch, write and read traffic, including stray high bytes on second halves, runs against a reference model in the bench. Directed cases cover held strobes, a latch combined with a write, and a latch that cuts a program word in half.

// File: rtl/mdsp_pkg.sv
package mdsp_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_LATCH = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } mdsp_op_e;
endpackage

// File: rtl/mdsp_decode.sv
module mdsp_decode
   import mdsp_pkg::*;
(
   input  logic     sel_n,
   input  logic     latch,
   input  logic     rd_n,
   input  logic     wr_n,
   input  logic     ready,
   output mdsp_op_e op
);
   // latch outranks write, write outranks read
   always_comb begin
      op = OP_IDLE;
      if (!sel_n && ready) begin
         if (latch)      op = OP_LATCH;
         else if (!wr_n) op = OP_WRITE;
         else if (!rd_n) op = OP_READ;
      end
   end
endmodule

// File: rtl/mdsp_addr_unit.sv
module mdsp_addr_unit
   import mdsp_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mdsp_op_e          op,
   input  logic [ADDR_W:0]   latch_val,
   output logic [ADDR_W-1:0] addr,
   output logic              is_dm,
   output logic              half
);
   localparam int TYPE_BIT = ADDR_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         is_dm <= 1'b0;
         half  <= 1'b0;
      end else begin
         case (op)
            OP_LATCH: begin
               addr  <= latch_val[ADDR_W-1:0];
               is_dm <= latch_val[TYPE_BIT];
               half  <= 1'b0;
            end
            OP_WRITE, OP_READ: begin
               if (is_dm) begin
                  addr <= addr + ADDR_W'(1);
               end else if (!half) begin
                  half <= 1'b1;
               end else begin
                  half <= 1'b0;
                  addr <= addr + ADDR_W'(1);
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mdsp_mem.sv
module mdsp_mem #(
   parameter int WIDTH  = 16,
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   output logic [WIDTH-1:0]  rdata
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("mdsp_mem: DEPTH must be a power of two");
   end
   if (IDX_W > ADDR_W) begin : g_bad_span
      $error("mdsp_mem: DEPTH exceeds the address space");
   end

   logic [IDX_W-1:0] idx;

   if (IDX_W == ADDR_W) begin : g_full
      assign idx = addr;
   end else begin : g_alias
      assign idx = IDX_W'(addr % ADDR_W'(DEPTH));
   end

   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[idx] <= wdata;
   end

   assign rdata = cells[idx];
endmodule

// File: rtl/mdsp_host_port.sv
module mdsp_host_port
   import mdsp_pkg::*;
#(
   parameter int BUS_W    = 16,
   parameter int PM_W     = 24,
   parameter int ADDR_W   = 14,
   parameter int PM_DEPTH = 1024,
   parameter int DM_DEPTH = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_en,
   input  logic             sel_n,
   input  logic             latch,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic [BUS_W-1:0] bus_in,
   output logic [BUS_W-1:0] bus_out,
   output logic             ack_n,
   output logic             boot_done
);
   localparam int LO_W = PM_W - BUS_W;

   if (LO_W < 1 || LO_W > BUS_W) begin : g_bad_pm
      $error("mdsp_host_port: PM_W must lie between BUS_W+1 and 2*BUS_W");
   end
   if (BUS_W < ADDR_W + 1) begin : g_bad_bus
      $error("mdsp_host_port: bus too narrow for address plus type bit");
   end

   logic              busy;
   mdsp_op_e          op;
   logic [ADDR_W-1:0] addr;
   logic              is_dm;
   logic              half;
   logic [BUS_W-1:0]  hold;
   logic              pm_we, dm_we;
   logic [PM_W-1:0]   pm_rdata;
   logic [BUS_W-1:0]  dm_rdata;

   mdsp_decode u_dec (
      .sel_n (sel_n),
      .latch (latch),
      .rd_n  (rd_n),
      .wr_n  (wr_n),
      .ready (!busy),
      .op    (op)
   );

   mdsp_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .latch_val (bus_in[ADDR_W:0]),
      .addr      (addr),
      .is_dm     (is_dm),
      .half      (half)
   );

   assign pm_we = (op == OP_WRITE) && !is_dm && half;
   assign dm_we = (op == OP_WRITE) && is_dm;

   mdsp_mem #(.WIDTH(PM_W), .DEPTH(PM_DEPTH), .ADDR_W(ADDR_W)) u_pm (
      .clk   (clk),
      .we    (pm_we),
      .addr  (addr),
      .wdata ({hold, bus_in[LO_W-1:0]}),
      .rdata (pm_rdata)
   );

   mdsp_mem #(.WIDTH(BUS_W), .DEPTH(DM_DEPTH), .ADDR_W(ADDR_W)) u_dm (
      .clk   (clk),
      .we    (dm_we),
      .addr  (addr),
      .wdata (bus_in),
      .rdata (dm_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         hold      <= '0;
         bus_out   <= '0;
         boot_done <= 1'b0;
      end else begin
         busy <= (op != OP_IDLE);
         if (op == OP_WRITE && !is_dm && !half) hold <= bus_in;
         if (op == OP_READ) begin
            if (is_dm)     bus_out <= dm_rdata;
            else if (half) bus_out <= {{(BUS_W-LO_W){1'b0}}, pm_rdata[LO_W-1:0]};
            else           bus_out <= pm_rdata[PM_W-1 -: BUS_W];
         end
         if (pm_we && boot_en && addr == '0) boot_done <= 1'b1;
      end
   end

   assign ack_n = busy;
endmodule

// File: rtl/mdsp_port_chk.sv
module mdsp_port_chk #(
   parameter int BUS_W = 16,
   parameter int PM_W  = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             boot_en,
   input logic             sel_n,
   input logic             latch,
   input logic             rd_n,
   input logic             wr_n,
   input logic [BUS_W-1:0] bus_out,
   input logic             ack_n,
   input logic             boot_done,
   input logic             is_dm,
   input logic             half
);
   localparam int LO_W = PM_W - BUS_W;

   logic acc, rd_only;
   assign acc     = !sel_n && !ack_n && (latch || !rd_n || !wr_n);
   assign rd_only = acc && !latch && wr_n && !rd_n;

   assert_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> ack_n);

   assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_n |=> !ack_n);

   assert_boot_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done |=> boot_done);

   assert_boot_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boot_done) |-> $past(acc && !latch && !wr_n && boot_en && !is_dm && half));

   assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_only |=> $stable(bus_out));

   assert_lo_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && !is_dm && half) |=> (bus_out[BUS_W-1:LO_W] == '0));

   assert_latch_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && latch && !wr_n) |=> (boot_done == $past(boot_done)));
endmodule

bind mdsp_host_port mdsp_port_chk #(.BUS_W(BUS_W), .PM_W(PM_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .boot_en   (boot_en),
   .sel_n     (sel_n),
   .latch     (latch),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .bus_out   (bus_out),
   .ack_n     (ack_n),
   .boot_done (boot_done),
   .is_dm     (is_dm),
   .half      (half)
);

// File: tb/tb_mdsp_host_port.sv
module tb_mdsp_host_port;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_en = 1'b0;
   logic        sel_n = 1'b1;
   logic        latch = 1'b0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic [15:0] bus_in = '0;
   logic [15:0] bus_out;
   logic        ack_n;
   logic        boot_done;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdsp_host_port dut (
      .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .sel_n(sel_n),
      .latch(latch), .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in),
      .bus_out(bus_out), .ack_n(ack_n), .boot_done(boot_done)
   );

   // reference model state
   logic [23:0] pm_m [DEPTH];
   logic [15:0] dm_m [DEPTH];
   logic [13:0] m_addr = '0;
   bit          m_dm = 0, m_half = 0, m_boot = 0;
   logic [15:0] m_hold = '0;
   logic [15:0] m_out = '0;

   function automatic int idx(input logic [13:0] a);
      return int'(a) % DEPTH;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_apply(input int kind, input logic [15:0] d);
      case (kind)
         1: begin m_addr = d[13:0]; m_dm = d[14]; m_half = 0; end
         2: begin
            if (m_dm) begin
               dm_m[idx(m_addr)] = d; m_addr = m_addr + 14'd1;
            end else if (!m_half) begin
               m_hold = d; m_half = 1;
            end else begin
               pm_m[idx(m_addr)] = {m_hold, d[7:0]};
               if (boot_en && m_addr == 14'd0) m_boot = 1;
               m_half = 0; m_addr = m_addr + 14'd1;
            end
         end
         3: begin
            if (m_dm) begin
               m_out = dm_m[idx(m_addr)]; m_addr = m_addr + 14'd1;
            end else if (!m_half) begin
               m_out = pm_m[idx(m_addr)][23:8]; m_half = 1;
            end else begin
               m_out = {8'h00, pm_m[idx(m_addr)][7:0]};
               m_half = 0; m_addr = m_addr + 14'd1;
            end
         end
         default: ;
      endcase
   endtask

   task automatic bus_op(input bit l, input bit r, input bit w,
                         input logic [15:0] d, input int cycles);
      int kind;
      @(negedge clk);
      sel_n = 1'b0; latch = l; rd_n = !r; wr_n = !w; bus_in = d;
      repeat (cycles) @(negedge clk);
      sel_n = 1'b1; latch = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
      bus_in = 16'($urandom);
      kind = l ? 1 : (w ? 2 : (r ? 3 : 0));
      model_apply(kind, d);
      if (cycles == 1) chk("R6 ack busy after access", 32'(ack_n), 32'd1);
   endtask

   task automatic do_latch(input logic [15:0] d);
      bus_op(1, 0, 0, d, 1);
   endtask

   task automatic do_write(input logic [15:0] d);
      bus_op(0, 0, 1, d, 1);
   endtask

   task automatic do_read(input string req);
      bus_op(0, 1, 0, 16'h0, 1);
      chk(req, 32'(bus_out), 32'(m_out));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [15:0] saved;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1 ack_n in reset", 32'(ack_n), 32'd0);
      chk("R1 boot_done in reset", 32'(boot_done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ack_n after reset", 32'(ack_n), 32'd0);
      chk("R1 boot_done after reset", 32'(boot_done), 32'd0);
      chk("R1 bus_out after reset", 32'(bus_out), 32'd0);

      // fill both memories, boot mode off
      do_latch(16'h4000);
      for (int i = 0; i < DEPTH; i++) do_write(16'($urandom));
      do_latch(16'h0000);
      for (int i = 0; i < DEPTH; i++) begin
         do_write(16'($urandom));
         do_write(16'($urandom));
      end
      chk("R9 no flag with boot_en low", 32'(boot_done), 32'd0);

      // R3 data words, R2 bit 15 ignored
      do_latch(16'hC005);
      do_write(16'h1111); do_write(16'h2222); do_write(16'h3333);
      do_latch(16'h4005);
      do_read("R3 dm word 0"); do_read("R3 dm word 1"); do_read("R3 dm word 2");
      chk("R2 dm latch incl bit15", 32'(bus_out), 32'h3333);

      // R4 / R5 program words
      do_latch(16'h0010);
      do_write(16'hABCD); do_write(16'h5AEF);
      do_write(16'h0102); do_write(16'hFF03);
      do_latch(16'h0010);
      do_read("R5 pm upper");
      chk("R4 pm upper value", 32'(bus_out), 32'hABCD);
      do_read("R5 pm lower");
      chk("R4 pm lower byte, high byte ignored", 32'(bus_out), 32'h00EF);
      do_read("R5 pm next upper"); do_read("R5 pm next lower");
      chk("R5 pm lower zero-extended", 32'(bus_out), 32'h0003);

      // R6 strobe held through busy cycle counts once
      do_latch(16'h4020);
      bus_op(0, 0, 1, 16'h7777, 2);
      do_write(16'h8888);
      do_latch(16'h4020);
      do_read("R6 held write once");
      do_read("R6 next write lands at +1");
      chk("R6 value at +1", 32'(bus_out), 32'h8888);

      // R7 latch together with write
      do_latch(16'h4030);
      saved = dm_m[16'h30];
      bus_op(1, 0, 1, 16'h4040, 1);
      do_read("R7 read after latch+write uses new address");
      do_latch(16'h4030);
      do_read("R7 old location unchanged");
      chk("R7 old value", 32'(bus_out), 32'(saved));

      // R8 latch discards half word
      do_latch(16'h0050);
      do_write(16'h1234);
      do_latch(16'h0050);
      do_write(16'hBEEF); do_write(16'h0042);
      do_latch(16'h0050);
      do_read("R8 upper after restart");
      chk("R8 upper value", 32'(bus_out), 32'hBEEF);
      do_read("R8 lower after restart");

      // R11 write wins over read; output holds across writes
      do_latch(16'h4060);
      bus_op(0, 1, 1, 16'h9A9A, 1);
      do_latch(16'h4060);
      do_read("R11 rd+wr acts as write");
      chk("R11 stored value", 32'(bus_out), 32'h9A9A);
      do_write(16'h0F0F); do_latch(16'h0000);
      chk("R11 bus_out held over writes", 32'(bus_out), 32'h9A9A);

      // R9 / R10 boot through wrap
      boot_en = 1'b1;
      do_latch(16'h3FFF);
      do_write(16'h1357); do_write(16'h0024);
      chk("R9 no flag at 0x3FFF", 32'(boot_done), 32'd0);
      do_write(16'hC0DE);
      chk("R9 no flag after first half", 32'(boot_done), 32'd0);
      do_write(16'h3399);
      chk("R9 flag after restart vector", 32'(boot_done), 32'd1);
      do_latch(16'h0000);
      do_read("R10 word at 0 upper");
      chk("R10 wrapped write upper", 32'(bus_out), 32'hC0DE);
      do_read("R10 word at 0 lower");
      do_latch(16'h0400);
      do_read("R10 aliased upper");
      do_latch(16'h03FF);
      do_read("R10 0x3FFF aliases 0x3FF");
      chk("R10 alias value", 32'(bus_out), 32'h1357);

      // constrained random traffic
      for (int n = 0; n < 600; n++) begin
         int pick;
         pick = int'($urandom % 8);
         if (pick == 0)      do_latch(16'($urandom));
         else if (pick < 5)  do_write(16'($urandom));
         else                do_read("R3 R5 random read");
         if (n % 50 == 0) chk("R9 flag sticky", 32'(boot_done), 32'(m_boot));
      end

      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 flag cleared by reset", 32'(boot_done), 32'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule